// File: doc/BRIEF.md
# Timer Compare Channel Pulse Generator

A bank of compare channels that watches an external, free-running 31-bit timestamp counter. Each channel holds an armed compare point. On the clock edge where the counter equals that point, the channel does three things: it sets its event flag, it may raise the shared interrupt, and it drives its own output pin according to its mode. A one-cycle pulse at each match gives a pulse-per-second style output. A toggle mode gives a square wave. Software programs the channels through a small register-write and register-read bus.

The compare point is double-buffered. While the armed point is still pending, software can queue the point after it. At each match the queued point moves into the armed slot, and software then writes the point after that. A channel is set up in a fixed order: first clear its mode, then write the first compare point, then select a mode. A compare write made while the mode is non-zero fills the queue slot.

Each channel is a three-state machine:
- `CH_IDLE`: nothing is armed.
- `CH_ARMED`: one point is held.
- `CH_QUEUED`: an armed point and a queued point are both held.

The transitions are:
- **arm**: a compare write while idle goes to `CH_ARMED`.
- **rearm**: a compare write while armed and the mode is zero replaces the armed point.
- **queue**: a compare write while armed and the mode is non-zero goes to `CH_QUEUED`.
- **replace**: a compare write while queued overwrites the queued point.
- **advance**: a match while queued goes back to `CH_ARMED` with the queued point.
- **retire**: a match while armed goes to `CH_IDLE`.
- **kill**: a control write with a mode of zero goes to `CH_IDLE` from any state and clears both points.

Top module: `tcb_bank`

## Requirements
- R1: Register map. The status register is at 0x604 and holds the channel n event flag in bit n. The control register of channel n is at 0x608+8n and its compare register is at 0x60C+8n. Control register bit fields: mode in bits 5:2, interrupt enable in bit 6, event flag in bit 7. All other bits, and reads of unmapped addresses, return 0.
- R2: A compare write while the channel is idle, or while it is armed with a mode of zero, sets the armed point. A compare read returns the armed point, or 0 when nothing is armed.
- R3: With mode 0xF, the pin is high for exactly one clock cycle. That cycle follows the clock edge at which the counter equals the armed point.
- R4: With mode 0x5, the pin inverts after each matching edge. With any other non-zero mode, the pin stays low.
- R5: A compare write while armed with a non-zero mode queues the value. A further write while queued replaces the queued value. At a match, the queued value becomes the armed point.
- R6: A match with nothing queued returns the channel to idle. No further events occur until a new point is written.
- R7: A match sets the event flag. Writing 1 to bit 7 clears the flag and writing 0 leaves it unchanged. A match in the same cycle as a clear wins.
- R8: The interrupt output is high exactly when some channel has both its flag and its interrupt enable set.
- R9: While `pin_en` is low, matches still set flags but no pin pulses or toggles.
- R10: Writing a control value whose mode field is 0 clears the armed and queued points and drives the pin low on the next cycle.
- R11: Compare points are taken modulo 2^31. Written bits above bit 30 are ignored, and matches across the counter wrap work.
- R12: A counter value produces at most one match, even when the counter holds that value for several cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| counter | input | CNT_W | Free-running timestamp counter value |
| pin_en | input | 1 | Global enable for compare-driven pin activity |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for `bus_addr` (combinational) |
| cmp_pins | output | NUM_CH | One compare output pin per channel |
| irq | output | 1 | Combined channel interrupt |

## Verification
The bench builds the block with its defaults: four channels, a 31-bit counter, 12-bit addresses and 32-bit data. Because the counter is a bench-driven input, the bench can jump it to just below 2^31 - 1, which makes a match across the wrap reachable in a few cycles. The bench can also freeze the counter on a matching value, which exercises the one-match-per-value rule. All four channels are used, so the status register, pulse mode, toggle mode, disabled pins and the interrupt combination each get their own channel.

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_ARMED  = 2'd1,
        CH_QUEUED = 2'd2
    } ch_state_e;

    localparam logic [3:0] MODE_OFF    = 4'h0;
    localparam logic [3:0] MODE_TOGGLE = 4'h5;
    localparam logic [3:0] MODE_PULSE  = 4'hF;

    localparam int CSR_MODE_LSB = 2;
    localparam int CSR_IE_BIT   = 6;
    localparam int CSR_FLAG_BIT = 7;

    localparam int STATUS_OFS  = 'h604;
    localparam int CH_BASE_OFS = 'h608;
    localparam int CH_STRIDE   = 8;
    localparam int CMP_REL_OFS = 4;

endpackage

// File: rtl/tcb_channel.sv
module tcb_channel
    import tcb_pkg::*;
#(
    parameter int CNT_W  = 31,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  counter,
    input  logic              cnt_new,
    input  logic              pin_en,
    input  logic              csr_we,
    input  logic              cmp_we,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit,
    output logic              flag,
    output logic              ie,
    output logic [3:0]        mode,
    output logic [CNT_W-1:0]  cmp_rd,
    output logic              live,
    output logic              pin
);

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] armed_q, armed_d, next_q, next_d;
    logic [3:0]       mode_q, wr_mode;
    logic             ie_q, flag_q, pin_q, kill;
    logic [CNT_W-1:0] wval;
    logic             unused_hi;

    assign wr_mode   = wdata[CSR_MODE_LSB +: 4];
    assign wval      = wdata[CNT_W-1:0];
    assign unused_hi = ^wdata[DATA_W-1:CNT_W];
    assign kill      = csr_we && (wr_mode == MODE_OFF);
    assign hit       = (st_q != CH_IDLE) && (mode_q != MODE_OFF) && cnt_new
                       && (counter == armed_q);

    // Next-state logic: match first, then bus write, kill overrides.
    always_comb begin
        st_d    = st_q;
        armed_d = armed_q;
        next_d  = next_q;
        if (hit) begin
            unique case (st_q)
                CH_QUEUED: begin
                    st_d    = CH_ARMED;   // advance
                    armed_d = next_q;
                end
                CH_ARMED: begin
                    st_d    = CH_IDLE;    // retire
                    armed_d = '0;
                end
                default: ;
            endcase
        end
        if (cmp_we) begin
            unique case (st_d)
                CH_IDLE: begin
                    st_d    = CH_ARMED;   // arm
                    armed_d = wval;
                end
                CH_ARMED: begin
                    if (mode_q == MODE_OFF) begin
                        armed_d = wval;   // rearm
                    end else begin
                        st_d   = CH_QUEUED; // queue
                        next_d = wval;
                    end
                end
                CH_QUEUED: next_d = wval; // replace
                default: ;
            endcase
        end
        if (kill) begin
            st_d    = CH_IDLE;
            armed_d = '0;
            next_d  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= CH_IDLE;
            armed_q <= '0;
            next_q  <= '0;
        end else begin
            st_q    <= st_d;
            armed_q <= armed_d;
            next_q  <= next_d;
        end
    end

    // Outputs: control fields, flag and pin.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            ie_q   <= 1'b0;
            flag_q <= 1'b0;
            pin_q  <= 1'b0;
        end else begin
            if (csr_we) begin
                mode_q <= wr_mode;
                ie_q   <= wdata[CSR_IE_BIT];
            end
            if (hit)
                flag_q <= 1'b1;
            else if (csr_we && wdata[CSR_FLAG_BIT])
                flag_q <= 1'b0;
            if (kill) begin
                pin_q <= 1'b0;
            end else begin
                unique case (mode_q)
                    MODE_PULSE:  pin_q <= hit && pin_en;
                    MODE_TOGGLE: if (hit && pin_en) pin_q <= !pin_q;
                    default:     pin_q <= 1'b0;
                endcase
            end
        end
    end

    assign flag   = flag_q;
    assign ie     = ie_q;
    assign mode   = mode_q;
    assign pin    = pin_q;
    assign live   = (st_q != CH_IDLE);
    assign cmp_rd = live ? armed_q : '0;

endmodule

// File: rtl/tcb_regif.sv
module tcb_regif
    import tcb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [NUM_CH-1:0]             flags,
    input  logic [NUM_CH-1:0][7:0]        csr_rd,
    input  logic [NUM_CH-1:0][CNT_W-1:0]  cmp_rd,
    output logic [NUM_CH-1:0]             csr_we,
    output logic [NUM_CH-1:0]             cmp_we,
    output logic [DATA_W-1:0]             bus_rdata
);

    localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'(CH_BASE_OFS + CH_STRIDE * i);
        localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CH_BASE_OFS + CH_STRIDE * i + CMP_REL_OFS);
        assign csr_we[i] = bus_wr && (bus_addr == CSR_A);
        assign cmp_we[i] = bus_wr && (bus_addr == CMP_A);
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STATUS_A)
            bus_rdata[NUM_CH-1:0] = flags;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_BASE_OFS + CH_STRIDE * i))
                bus_rdata[7:0] = csr_rd[i];
            if (bus_addr == ADDR_W'(CH_BASE_OFS + CH_STRIDE * i + CMP_REL_OFS))
                bus_rdata[CNT_W-1:0] = cmp_rd[i];
        end
    end

endmodule

// File: rtl/tcb_bank.sv
module tcb_bank
    import tcb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  counter,
    input  logic              pin_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] cmp_pins,
    output logic              irq
);

    logic [CNT_W-1:0]             cnt_prev;
    logic                         prev_vld, cnt_new;
    logic [NUM_CH-1:0]            ch_hit, ch_flag, ch_ie, ch_live, csr_we, cmp_we;
    logic [NUM_CH-1:0][3:0]       ch_mode;
    logic [NUM_CH-1:0][7:0]       csr_rd;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_prev <= '0;
            prev_vld <= 1'b0;
        end else begin
            cnt_prev <= counter;
            prev_vld <= 1'b1;
        end
    end
    assign cnt_new = !prev_vld || (counter != cnt_prev);

    tcb_regif #(
        .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regif (
        .bus_wr(bus_wr), .bus_addr(bus_addr), .flags(ch_flag),
        .csr_rd(csr_rd), .cmp_rd(cmp_rd), .csr_we(csr_we), .cmp_we(cmp_we),
        .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tcb_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .counter(counter), .cnt_new(cnt_new),
            .pin_en(pin_en), .csr_we(csr_we[i]), .cmp_we(cmp_we[i]),
            .wdata(bus_wdata), .hit(ch_hit[i]), .flag(ch_flag[i]),
            .ie(ch_ie[i]), .mode(ch_mode[i]), .cmp_rd(cmp_rd[i]),
            .live(ch_live[i]), .pin(cmp_pins[i])
        );
        assign csr_rd[i] = {ch_flag[i], ch_ie[i], ch_mode[i], 2'b00};
    end

    assign irq = |(ch_flag & ch_ie);

endmodule

// File: rtl/tcb_bank_chk.sv
module tcb_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 31,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  counter,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_CH-1:0] cmp_pins,
    input logic              irq,
    input logic [NUM_CH-1:0] ch_hit,
    input logic [NUM_CH-1:0] ch_flag,
    input logic [NUM_CH-1:0] ch_live
);

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ch_flag != '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] CSR_A = ADDR_W'('h608 + 8 * i);

        assert_flag_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ch_flag[i]) |-> $past(bus_wr && (bus_addr == CSR_A) && bus_wdata[7]));

        assert_kill_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && (bus_addr == CSR_A) && (bus_wdata[5:2] == 4'h0))
            |=> (!cmp_pins[i] && !ch_live[i]));

        assert_one_hit_per_value_R12: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_hit[i] && $past(ch_hit[i])) |-> (counter != $past(counter)));

        assert_pin_rise_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cmp_pins[i]) |-> ch_flag[i]);
    end

endmodule

bind tcb_bank tcb_bank_chk #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .counter(counter), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cmp_pins(cmp_pins),
    .irq(irq), .ch_hit(ch_hit), .ch_flag(ch_flag), .ch_live(ch_live)
);

// File: tb/tcb_bank_tb.sv
`timescale 1ns/1ps
module tcb_bank_tb;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 31;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [7:0]       ch;
        logic [CNT_W-1:0] val;
    } evt_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  cnt = 31'h7FFF_FFD0;
    logic              cnt_run = 1'b1;
    logic              pin_en = 1'b1;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_CH-1:0] cmp_pins;
    logic              irq;

    int   n_chk = 0;
    int   n_err = 0;
    evt_t exp_q[$];
    int   tb_mode [NUM_CH] = '{default: 0}; // 0 ignore, 1 pulse, 2 toggle

    tcb_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .counter(cnt), .pin_en(pin_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .cmp_pins(cmp_pins), .irq(irq)
    );

    initial forever #10 clk = ~clk;

    initial forever begin
        @(negedge clk);
        if (cnt_run) cnt <= cnt + 31'd1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] csr_a(input int c);
        return ADDR_W'('h608 + 8 * c);
    endfunction

    function automatic logic [ADDR_W-1:0] cmp_a(input int c);
        return ADDR_W'('h60C + 8 * c);
    endfunction

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk); #1;
        bus_addr = a;
        #2 d = bus_rdata;
    endtask

    task automatic set_cnt(input logic [CNT_W-1:0] v);
        @(negedge clk); #1;
        cnt = v;
    endtask

    task automatic wait_cnt(input logic [CNT_W-1:0] v);
        do begin
            @(negedge clk); #1;
        end while (cnt != v);
    endtask

    task automatic expect_evt(input int c, input logic [CNT_W-1:0] v);
        evt_t e;
        e.ch  = 8'(c);
        e.val = v;
        exp_q.push_back(e);
    endtask

    // Monitor: pin events are matched against the scoreboard queue.
    initial begin
        logic [NUM_CH-1:0] prev;
        prev = '0;
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    bit   ev;
                    evt_t e;
                    ev = (tb_mode[c] == 1 && cmp_pins[c]) ||
                         (tb_mode[c] == 2 && cmp_pins[c] != prev[c]);
                    if (ev) begin
                        if (exp_q.size() == 0) begin
                            chk(1'b0, "R3 R4 R9 R10 R12 unexpected pin event", 32'(cnt), 32'(c));
                        end else begin
                            e = exp_q.pop_front();
                            chk(e.ch == 8'(c) && e.val == cnt, "R3 R4 R11 pin event channel/time",
                                {1'b0, cnt}, {1'b0, e.val});
                        end
                    end
                end
            end
            prev = cmp_pins;
        end
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic [CNT_W-1:0]  c0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // Reset state
        chk(cmp_pins == '0, "R1 reset pins", 32'(cmp_pins), 0);
        chk(irq == 1'b0, "R8 reset irq", 32'(irq), 0);
        rd(12'h604, d); chk(d == 0, "R1 reset status", d, 0);
        rd(csr_a(0), d); chk(d == 0, "R1 reset control", d, 0);
        rd(cmp_a(0), d); chk(d == 0, "R2 reset compare idle", d, 0);

        // Single pulse on channel 0
        tb_mode[0] = 1;
        wr(csr_a(0), 32'h0);
        c0 = cnt + 31'd30;
        wr(cmp_a(0), {1'b0, c0});
        rd(cmp_a(0), d); chk(d == {1'b0, c0}, "R2 armed readback", d, {1'b0, c0});
        wr(csr_a(0), 32'h7C);
        rd(csr_a(0), d); chk(d == 32'h7C, "R1 control fields", d, 32'h7C);
        expect_evt(0, c0);
        wait_cnt(c0 + 31'd3);
        rd(csr_a(0), d); chk(d == 32'hFC, "R7 flag set on match", d, 32'hFC);
        rd(12'h604, d); chk(d == 32'h1, "R8 status mirrors flag", d, 1);
        chk(irq == 1'b1, "R8 irq with flag and enable", 32'(irq), 1);
        rd(cmp_a(0), d); chk(d == 0, "R6 disarm without queue", d, 0);

        // Write-one-to-clear
        wr(csr_a(0), 32'h3C);
        rd(csr_a(0), d); chk(d == 32'hBC, "R7 writing 0 keeps flag", d, 32'hBC);
        chk(irq == 1'b0, "R8 irq needs enable", 32'(irq), 0);
        wr(csr_a(0), 32'hBC);
        rd(csr_a(0), d); chk(d == 32'h3C, "R7 writing 1 clears flag", d, 32'h3C);
        rd(12'h604, d); chk(d == 0, "R8 status after clear", d, 0);

        // Queue, replace and wrap on channel 0
        wr(csr_a(0), 32'h0);
        set_cnt(31'h7FFF_FFE0);
        wr(cmp_a(0), 32'hFFFF_FFFC);
        wr(csr_a(0), 32'h3C);
        wr(cmp_a(0), 32'h4);
        wr(cmp_a(0), 32'h6);
        rd(cmp_a(0), d); chk(d == 32'h7FFF_FFFC, "R11 upper bit dropped", d, 32'h7FFF_FFFC);
        expect_evt(0, 31'h7FFF_FFFC);
        expect_evt(0, 31'h6);
        wait_cnt(31'd10);
        rd(cmp_a(0), d); chk(d == 0, "R5 R6 queue consumed then idle", d, 0);
        wr(csr_a(0), 32'hBC);

        // Toggle mode on channel 1
        tb_mode[1] = 2;
        wr(csr_a(1), 32'h0);
        set_cnt(31'd100);
        wr(cmp_a(1), 32'd120);
        wr(csr_a(1), 32'h14);
        wr(cmp_a(1), 32'd128);
        expect_evt(1, 31'd120);
        expect_evt(1, 31'd128);
        wait_cnt(31'd132);
        chk(cmp_pins[1] == 1'b0, "R4 two toggles return low", 32'(cmp_pins[1]), 0);
        wr(cmp_a(1), 32'd145);
        expect_evt(1, 31'd145);
        wait_cnt(31'd148);
        chk(cmp_pins[1] == 1'b1, "R4 toggle high", 32'(cmp_pins[1]), 1);

        // Disable clears both points and the pin
        tb_mode[1] = 0;
        wr(cmp_a(1), 32'd165);
        wr(cmp_a(1), 32'd170);
        wr(csr_a(1), 32'h0);
        chk(cmp_pins[1] == 1'b0, "R10 pin low after disable", 32'(cmp_pins[1]), 0);
        rd(cmp_a(1), d); chk(d == 0, "R10 armed cleared", d, 0);
        wr(csr_a(1), 32'h14);
        tb_mode[1] = 2;
        wait_cnt(31'd175);
        chk(cmp_pins[1] == 1'b0, "R10 no event from cleared points", 32'(cmp_pins[1]), 0);

        // Pins held off globally on channel 2
        tb_mode[2] = 1;
        wr(csr_a(2), 32'h0);
        set_cnt(31'd200);
        wr(cmp_a(2), 32'd215);
        pin_en = 1'b0;
        wr(csr_a(2), 32'h3C);
        wait_cnt(31'd220);
        chk(cmp_pins == '0, "R9 no pin activity when disabled", 32'(cmp_pins), 0);
        rd(12'h604, d); chk(d[2] == 1'b1, "R9 match still flagged", d, 32'h4);
        chk(irq == 1'b0, "R8 flag without enable", 32'(irq), 0);
        pin_en = 1'b1;

        // One match per counter value on channel 3
        tb_mode[3] = 1;
        wr(csr_a(3), 32'h0);
        set_cnt(31'd300);
        wr(cmp_a(3), 32'd320);
        wr(csr_a(3), 32'h7C);
        wr(cmp_a(3), 32'd320);
        expect_evt(3, 31'd320);
        wait_cnt(31'd320);
        cnt_run = 1'b0;
        repeat (4) @(negedge clk);
        #1 cnt_run = 1'b1;
        repeat (3) @(negedge clk);
        rd(cmp_a(3), d); chk(d == 32'd320, "R12 R5 queued point loaded, no refire", d, 32'd320);
        rd(12'h604, d); chk(d == 32'hE, "R8 status across channels", d, 32'hE);
        chk(irq == 1'b1, "R8 irq from channel 3", 32'(irq), 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 R5 all expected events seen", 32'(exp_q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule